// File: doc/BRIEF.md
# System Control Register Block

A 32-bit register block that sits on an APB-style slave port and decodes a 4 KB window of word addresses. Software uses it to read and change secure-debug status bits, to see why the system last came out of reset, to keep one word across warm resets, to set the boot vector-table base of each core, to hold cores in a wait state and release them, and to request a system reset. Every access completes with no wait states. A write takes effect at the clock edge of its access phase (`psel && penable && pwrite`). Read data is combinational from `paddr` while `psel` is high and `pwrite` is low, and is zero at all other times.

Some writes have side effects. The debug set and clear words change a shared status word. Clearing a core's wait bit from 1 to 0 sends that core a one-cycle release pulse. One bit of the software-reset word sends a one-cycle reset request. The `VERSION` parameter selects a base or an extended variant, and the extended variant adds clock-divider, clock-force, early-wake, second-vector and power-domain-sense registers. Clock division and power sequencing themselves are outside this block; the registers only hold values.

Two resets are provided. `por_n` clears everything. `warm_n` reinitialises everything except the retention word.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, every register reads its reset value. These are 1 for the reset-cause word at 0x100, 0x7F for system power-sense at 0x200, `VTOR0_RST` and `VTOR1_RST` for the vector bases at 0x110 and 0x114, `WAIT_RST` for core wait at 0x118, and 0 for all others.
- R2: Writing 0x004 ORs the write data into the debug status word at 0x000. Writing 0x008 clears each status bit whose data bit is 1.
- R3: Offsets 0x004, 0x008 and 0x108 are write-only and read as zero.
- R4: A write to 0x108 with data bit 9 set makes `sys_reset_req` high for exactly the one cycle after the write edge. A write to 0x108 with bit 9 clear has no effect.
- R5: A write to 0x118 stores the data. For each core n (n = 0, 1), if bit n changes from 1 to 0, `core_release[n]` is high for exactly the one cycle after the write edge. Any other transition of bit n gives no pulse.
- R6: The extended variant is selected when `VERSION[31:28]` is 2. Otherwise the extended-only offsets (0x00C, 0x010, 0x014, 0x018, 0x114, 0x124, 0x200, 0x20C to 0x218) and 0x11C read zero and ignore writes.
- R7: Word offsets 0xFD0 to 0xFFC, in ascending order, read the bytes 04, 00, 00, 00, 54, B8, 0B, 00, 0D, F0, 05, B1, each zero-extended to 32 bits.
- R8: Writes to 0x000 and to the ID words have no effect.
- R9: Undecoded or non-word-aligned offsets read as zero and ignore writes.
- R10: A warm reset restores every register to its reset value except the retention word at 0x10C. A power-on reset clears the retention word as well.
- R11: `vtor0` and `vtor1` always show the current contents of 0x110 and 0x114.
- R12: The read/write registers (0x00C, 0x010, 0x014, 0x018, 0x100, 0x104, 0x10C, 0x110, 0x114, 0x11C, 0x120, 0x124, 0x200, 0x20C to 0x218 in the extended variant) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low |
| warm_n | input | 1 | Warm reset, async, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| core_release | output | 2 | One-cycle power-on-and-reset pulse per core |
| vtor0 | output | 32 | Core 0 initial vector-table base |
| vtor1 | output | 32 | Core 1 initial vector-table base |

## Verification
The bench builds two instances on one shared bus, each with its own select. One instance has `VERSION` = 0x2000_0000 and `WAIT_RST` = 3, so it has the extended register set and both cores start held. The other keeps the defaults, giving the base variant with cores not held. The first instance reaches the release-pulse sequences from the reset state and the extended read/write registers. The second shows that the extended offsets and 0x11C read as zero and that writes to them do not reach the vector output.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [4:0] {
    RG_SECCTL  = 5'd0,
    RG_FDIV    = 5'd1,
    RG_SDIV    = 5'd2,
    RG_CLKF    = 5'd3,
    RG_SYND    = 5'd4,
    RG_MASK    = 5'd5,
    RG_VTOR0   = 5'd6,
    RG_VTOR1   = 5'd7,
    RG_WAIT    = 5'd8,
    RG_NMI     = 5'd9,
    RG_WIC     = 5'd10,
    RG_EWC     = 5'd11,
    RG_PDSYS   = 5'd12,
    RG_PDS0    = 5'd13,
    RG_PDS1    = 5'd14,
    RG_PDS2    = 5'd15,
    RG_PDS3    = 5'd16,
    RG_DBGSTAT = 5'd17,
    RG_DBGSET  = 5'd18,
    RG_DBGCLR  = 5'd19,
    RG_SWRST   = 5'd20,
    RG_RETAIN  = 5'd21,
    RG_ID      = 5'd22,
    RG_NONE    = 5'd23
  } reg_id_e;

  // Plain read/write words occupy the low ids, one storage slot each
  localparam int NUM_PLAIN = 17;
  localparam int ID_WORDS  = 12;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h54;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           id
);
  reg_id_e raw;
  logic    ext_only;

  always_comb begin
    ext_only = 1'b0;
    case (addr)
      12'h000: raw = RG_DBGSTAT;
      12'h004: raw = RG_DBGSET;
      12'h008: raw = RG_DBGCLR;
      12'h00C: begin raw = RG_SECCTL; ext_only = 1'b1; end
      12'h010: begin raw = RG_FDIV;   ext_only = 1'b1; end
      12'h014: begin raw = RG_SDIV;   ext_only = 1'b1; end
      12'h018: begin raw = RG_CLKF;   ext_only = 1'b1; end
      12'h100: raw = RG_SYND;
      12'h104: raw = RG_MASK;
      12'h108: raw = RG_SWRST;
      12'h10C: raw = RG_RETAIN;
      12'h110: raw = RG_VTOR0;
      12'h114: begin raw = RG_VTOR1;  ext_only = 1'b1; end
      12'h118: raw = RG_WAIT;
      12'h11C: begin raw = RG_NMI;    ext_only = 1'b1; end
      12'h120: raw = RG_WIC;
      12'h124: begin raw = RG_EWC;    ext_only = 1'b1; end
      12'h200: begin raw = RG_PDSYS;  ext_only = 1'b1; end
      12'h20C: begin raw = RG_PDS0;   ext_only = 1'b1; end
      12'h210: begin raw = RG_PDS1;   ext_only = 1'b1; end
      12'h214: begin raw = RG_PDS2;   ext_only = 1'b1; end
      12'h218: begin raw = RG_PDS3;   ext_only = 1'b1; end
      default: raw = RG_NONE;
    endcase
    // ID window: word-aligned offsets 0xFD0..0xFFC
    if (addr[11:6] == 6'h3F && addr[5:4] != 2'b00 && addr[1:0] == 2'b00)
      raw = RG_ID;
  end

  generate
    if (EXT) begin : g_ext
      assign id = raw;
    end else begin : g_base
      assign id = ext_only ? RG_NONE : raw;
    end
  endgenerate
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] WAIT_RST  = '0,
  parameter logic [DATA_W-1:0] VTOR0_RST = 32'h1000_0000,
  parameter logic [DATA_W-1:0] VTOR1_RST = 32'h1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,   // warm or power-on
  input  logic              por_n,   // power-on only
  input  logic              wr_en,
  input  reg_id_e           id,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] plain_q [NUM_PLAIN],
  output logic [DATA_W-1:0] dbg_q,
  output logic [DATA_W-1:0] retain_q
);
  function automatic logic [DATA_W-1:0] rst_val(input int k);
    case (k)
      int'(RG_SYND):  rst_val = 32'd1;
      int'(RG_PDSYS): rst_val = 32'h0000_007F;
      int'(RG_VTOR0): rst_val = VTOR0_RST;
      int'(RG_VTOR1): rst_val = VTOR1_RST;
      int'(RG_WAIT):  rst_val = WAIT_RST;
      default:        rst_val = '0;
    endcase
  endfunction

  generate
    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          plain_q[i] <= rst_val(i);
        else if (wr_en && id == reg_id_e'(i))
          plain_q[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dbg_q <= '0;
    else if (wr_en && id == RG_DBGSET)
      dbg_q <= dbg_q | wdata;
    else if (wr_en && id == RG_DBGCLR)
      dbg_q <= dbg_q & ~wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      retain_q <= '0;
    else if (wr_en && id == RG_RETAIN)
      retain_q <= wdata;
  end
endmodule

// File: rtl/sysctl_pulses.sv
module sysctl_pulses #(
  parameter int NCORE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_wait,
  input  logic             wr_swrst,
  input  logic [NCORE-1:0] wait_old,
  input  logic [NCORE-1:0] wait_new,
  input  logic             req_bit,
  output logic [NCORE-1:0] release_o,
  output logic             sysreq_o
);
  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          release_o[c] <= 1'b0;
        else
          release_o[c] <= wr_wait & wait_old[c] & ~wait_new[c];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sysreq_o <= 1'b0;
    else
      sysreq_o <= wr_swrst & req_bit;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] VERSION   = 32'h0000_0000,
  parameter logic [31:0] WAIT_RST  = 32'h0000_0000,
  parameter logic [31:0] VTOR0_RST = 32'h1000_0000,
  parameter logic [31:0] VTOR1_RST = 32'h1000_0000,
  parameter int          NCORE     = 2,
  parameter int          SWRST_BIT = 9
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              sys_reset_req,
  output logic [NCORE-1:0]  core_release,
  output logic [DATA_W-1:0] vtor0,
  output logic [DATA_W-1:0] vtor1
);
  localparam bit EXT = (VERSION[31:28] == 4'd2);

  logic              rst_n;
  logic              wr_en;
  reg_id_e           id;
  logic [DATA_W-1:0] plain_q [NUM_PLAIN];
  logic [DATA_W-1:0] dbg_q;
  logic [DATA_W-1:0] retain_q;
  logic [3:0]        id_idx;

  assign rst_n = por_n & warm_n;
  assign wr_en = psel & penable & pwrite;

  sysctl_decode #(.EXT(EXT)) u_dec (
    .addr (paddr),
    .id   (id)
  );

  sysctl_regfile #(
    .WAIT_RST  (WAIT_RST),
    .VTOR0_RST (VTOR0_RST),
    .VTOR1_RST (VTOR1_RST)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .wr_en    (wr_en),
    .id       (id),
    .wdata    (pwdata),
    .plain_q  (plain_q),
    .dbg_q    (dbg_q),
    .retain_q (retain_q)
  );

  sysctl_pulses #(.NCORE(NCORE)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_wait   (wr_en && id == RG_WAIT),
    .wr_swrst  (wr_en && id == RG_SWRST),
    .wait_old  (plain_q[RG_WAIT][NCORE-1:0]),
    .wait_new  (pwdata[NCORE-1:0]),
    .req_bit   (pwdata[SWRST_BIT]),
    .release_o (core_release),
    .sysreq_o  (sys_reset_req)
  );

  assign id_idx = paddr[5:2] - 4'd4;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (int'(id) < NUM_PLAIN)
        prdata = plain_q[int'(id)];
      else if (id == RG_DBGSTAT)
        prdata = dbg_q;
      else if (id == RG_RETAIN)
        prdata = retain_q;
      else if (id == RG_ID)
        prdata = {{(DATA_W-8){1'b0}}, id_byte(id_idx)};
    end
  end

  assign vtor0 = plain_q[RG_VTOR0];
  assign vtor1 = plain_q[RG_VTOR1];
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int NCORE = 2
) (
  input logic             clk,
  input logic             por_n,
  input logic             warm_n,
  input logic             wr,
  input logic [11:0]      addr,
  input logic             d_rel0,
  input logic             d_req,
  input logic             sys_reset_req,
  input logic [NCORE-1:0] core_release,
  input logic [31:0]      vtor0
);
  // R4
  sysreq_single_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    sys_reset_req |=> !sys_reset_req);

  // R4
  sysreq_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    sys_reset_req |-> $past(wr && addr == 12'h108 && d_req));

  // R5
  release_single_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (|core_release) |=> (core_release == '0));

  // R5
  release_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    core_release[0] |-> $past(wr && addr == 12'h118 && !d_rel0));

  // R11
  vtor_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    !$stable(vtor0) |-> $past(wr && addr == 12'h110));
endmodule

bind sysctl_regs sysctl_regs_chk #(.NCORE(NCORE)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .warm_n        (warm_n),
  .wr            (psel & penable & pwrite),
  .addr          (paddr),
  .d_rel0        (pwdata[0]),
  .d_req         (pwdata[SWRST_BIT]),
  .sys_reset_req (sys_reset_req),
  .core_release  (core_release),
  .vtor0         (vtor0)
);

// File: tb/tb_sysctl_regs.sv
`timescale 1ns/1ps
module tb_sysctl_regs;
  logic        clk = 0;
  logic        por_n = 0, warm_n = 0;
  logic        psel_e = 0, psel_b = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_e, prdata_b, vtor0_e, vtor1_e, vtor0_b, vtor1_b;
  logic        req_e, req_b;
  logic [1:0]  rel_e, rel_b;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sysctl_regs #(.VERSION(32'h2000_0000), .WAIT_RST(32'd3)) dut (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .psel(psel_e), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_e),
    .sys_reset_req(req_e), .core_release(rel_e), .vtor0(vtor0_e), .vtor1(vtor1_e));

  sysctl_regs dut_base (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .psel(psel_b), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
    .sys_reset_req(req_b), .core_release(rel_b), .vtor0(vtor0_b), .vtor1(vtor1_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Returns at the negedge after the write edge (pulse cycle)
  task automatic wr(input bit ext, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel_e = ext; psel_b = !ext; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel_e = 0; psel_b = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input bit ext, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel_e = ext; psel_b = !ext; pwrite = 0; paddr = a; penable = 0;
    #1 d = ext ? prdata_e : prdata_b;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel_e = 0; psel_b = 0; penable = 0;
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    if (por) por_n = 0; else warm_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1; warm_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1, 12'h100, v); chk("R1 syndrome", v, 32'd1);
    rd(1, 12'h200, v); chk("R1 pd sys sense", v, 32'h7F);
    rd(1, 12'h118, v); chk("R1 ext wait", v, 32'd3);
    rd(0, 12'h118, v); chk("R1 base wait", v, 32'd0);
    rd(1, 12'h104, v); chk("R1 mask", v, 32'd0);
    rd(1, 12'h010, v); chk("R1 fdiv", v, 32'd0);
    rd(1, 12'h000, v); chk("R1 dbg status", v, 32'd0);
    chk("R1 R11 vtor0 port", vtor0_e, 32'h1000_0000);
    chk("R1 R11 vtor1 port", vtor1_b, 32'h1000_0000);
    chk("R1 no pulses", {29'd0, req_e, rel_e}, 32'd0);
  endtask

  task automatic t_debug;
    logic [31:0] v;
    wr(1, 12'h004, 32'h0F); rd(1, 12'h000, v); chk("R2 set", v, 32'h0F);
    wr(1, 12'h004, 32'hF0); rd(1, 12'h000, v); chk("R2 set or", v, 32'hFF);
    wr(1, 12'h008, 32'h3C); rd(1, 12'h000, v); chk("R2 clear", v, 32'hC3);
    rd(1, 12'h004, v); chk("R3 set reads zero", v, 0);
    rd(1, 12'h008, v); chk("R3 clr reads zero", v, 0);
    wr(1, 12'h000, 32'h0); rd(1, 12'h000, v); chk("R8 status ro", v, 32'hC3);
  endtask

  task automatic t_swrst;
    logic [31:0] v;
    wr(1, 12'h108, 32'hFFFF_FDFF); chk("R4 no req without bit9", {31'd0, req_e}, 0);
    rd(1, 12'h108, v); chk("R3 swreset reads zero", v, 0);
    wr(1, 12'h108, 32'h200); chk("R4 req pulse", {31'd0, req_e}, 1);
    @(negedge clk); chk("R4 req one cycle", {31'd0, req_e}, 0);
  endtask

  task automatic t_wait;
    logic [31:0] v;
    wr(1, 12'h118, 32'h2); chk("R5 release core0", {30'd0, rel_e}, 32'b01);
    @(negedge clk); chk("R5 pulse one cycle", {30'd0, rel_e}, 0);
    rd(1, 12'h118, v); chk("R5 stored", v, 32'h2);
    wr(1, 12'h118, 32'h2); chk("R5 1->1 no pulse", {30'd0, rel_e}, 0);
    wr(1, 12'h118, 32'h0); chk("R5 release core1", {30'd0, rel_e}, 32'b10);
    wr(1, 12'h118, 32'h3); chk("R5 0->1 no pulse", {30'd0, rel_e}, 0);
    wr(1, 12'h118, 32'h0); chk("R5 both release", {30'd0, rel_e}, 32'b11);
  endtask

  task automatic t_ext_rw;
    logic [31:0] v;
    wr(1, 12'h010, 32'h1234); rd(1, 12'h010, v); chk("R12 fdiv", v, 32'h1234);
    wr(1, 12'h11C, 32'h1); rd(1, 12'h11C, v); chk("R12 nmi", v, 32'h1);
    wr(1, 12'h214, 32'h55); rd(1, 12'h214, v); chk("R12 sram sense", v, 32'h55);
    wr(1, 12'h104, 32'hA0A0); rd(1, 12'h104, v); chk("R12 mask", v, 32'hA0A0);
    wr(1, 12'h114, 32'hABCD_0000); chk("R11 vtor1 port", vtor1_e, 32'hABCD_0000);
    wr(1, 12'h110, 32'h2000_0400); chk("R11 vtor0 port", vtor0_e, 32'h2000_0400);
  endtask

  task automatic t_base;
    logic [31:0] v;
    wr(0, 12'h010, 32'h77); rd(0, 12'h010, v); chk("R6 base fdiv", v, 0);
    wr(0, 12'h11C, 32'h1); rd(0, 12'h11C, v); chk("R6 base 0x11C", v, 0);
    rd(0, 12'h200, v); chk("R6 base pd sense", v, 0);
    wr(0, 12'h114, 32'h5555_0000); chk("R6 base vtor1 unchanged", vtor1_b, 32'h1000_0000);
    wr(0, 12'h120, 32'h9); rd(0, 12'h120, v); chk("R12 base wic", v, 32'h9);
  endtask

  task automatic t_id;
    logic [31:0] v;
    logic [7:0] exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 12; k++) begin
      rd(1, 12'hFD0 + 12'(k * 4), v); chk("R7 id word", v, {24'd0, exp[k]});
    end
    wr(1, 12'hFE0, 32'hFFFF); rd(1, 12'hFE0, v); chk("R8 id ro", v, 32'h54);
  endtask

  task automatic t_undec;
    logic [31:0] v;
    wr(1, 12'h300, 32'hDEAD); rd(1, 12'h300, v); chk("R9 undecoded", v, 0);
    rd(1, 12'h102, v); chk("R9 misaligned", v, 0);
    wr(1, 12'h106, 32'hBEEF); rd(1, 12'h104, v); chk("R9 misaligned write ignored", v, 32'hA0A0);
  endtask

  task automatic t_resets;
    logic [31:0] v;
    wr(1, 12'h10C, 32'hA5A5); rd(1, 12'h10C, v); chk("R12 retain", v, 32'hA5A5);
    do_reset(0);
    rd(1, 12'h10C, v); chk("R10 retain kept warm", v, 32'hA5A5);
    rd(1, 12'h104, v); chk("R10 mask warm", v, 0);
    rd(1, 12'h118, v); chk("R10 wait warm", v, 32'd3);
    chk("R10 vtor0 warm", vtor0_e, 32'h1000_0000);
    do_reset(1);
    rd(1, 12'h10C, v); chk("R10 retain por", v, 0);
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; warm_n = 1;
    @(negedge clk);
    t_reset();
    t_debug();
    t_swrst();
    t_wait();
    t_ext_rw();
    t_base();
    t_id();
    t_undec();
    t_resets();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule